// File: doc/BRIEF.md
# Reciprocal Table Multiply Divider

This block divides one unsigned 8-bit operand by another without any iterative subtract loop. The divisor selects an entry from a reciprocal table that is computed while the design elaborates. The dividend is then scaled by that fixed-point reciprocal with a single multiplier. A short compare step trims the estimate, so the result always matches floor division.

A new operand pair may be presented on any cycle, including every cycle. Each accepted pair produces exactly one result. The result appears a fixed two cycles later: the first cycle reads the table and the second multiplies and corrects. A zero divisor does not stall the pipeline. It yields an all-ones quotient and raises a flag that travels with that result.

Top module: `recip_divider`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly two rising clock edges. Each accepted pair yields exactly one result, and results come out in issue order.
- R2: Operand pairs may be accepted on consecutive cycles with no gap, and every one of them produces its own correct result.
- R3: For a nonzero divisor, `quotient` equals floor(dividend / divisor) for every combination of 8-bit operands.
- R4: The boundary cases hold. A divisor of 1 returns the dividend. A dividend smaller than the divisor returns 0. Equal nonzero operands return 1.
- R5: A divisor of 0 returns a quotient of 0xFF (all ones) and raises `div_zero` in the same cycle as `out_valid`.
- R6: `div_zero` is high only in a cycle where `out_valid` is high and the matching divisor was 0. It is low in every other cycle.
- R7: While `rst_n` is low, `out_valid` and `div_zero` are 0 and `quotient` is 0.
- R8: Operands presented while `in_valid` is low have no effect. No result is produced for them, and `quotient` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is presented this cycle |
| dividend | input | W (8) | Unsigned numerator |
| divisor | input | W (8) | Unsigned denominator |
| out_valid | output | 1 | Result is present this cycle |
| quotient | output | W (8) | Floor quotient, or all ones for a zero divisor |
| div_zero | output | 1 | The result belongs to a zero divisor |

## Verification
The bench builds the divider with its default operand width of 8 bits. At that width every one of the 65,536 dividend/divisor pairs can be issued back to back in a single run. The exhaustive sweep therefore covers every table entry, every zero-divisor pair and every place where the reciprocal estimate could round the wrong way. Directed pairs and gaps with changing idle operands come before the sweep, so that latency and the hold behaviour are also exercised with bubbles in the stream.

// File: rtl/recip_divider.sv
module recip_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         out_valid,
  output logic [W-1:0] quotient,
  output logic         div_zero
);
  localparam int W2    = 2 * W;
  localparam int RW    = W2 + 1;
  localparam int PW    = W + RW;
  localparam int DEPTH = 1 << W;

  function automatic int recip_val(input int d);
    if (d == 0) return 0;
    return ((1 << W2) + d - 1) / d;
  endfunction

  logic [RW-1:0] rtab [DEPTH];
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tab
    assign rtab[gi] = RW'(recip_val(gi));
  end

  logic          s1_valid;
  logic [W-1:0]  s1_num, s1_den;
  logic [RW-1:0] s1_recip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_num   <= dividend;
      s1_den   <= divisor;
      s1_recip <= rtab[divisor];
    end
  end

  logic [PW-1:0] prod;
  logic [W-1:0]  est, fixed;
  logic [W2-1:0] back;
  logic          den_zero;

  assign prod     = PW'(s1_num) * PW'(s1_recip);
  assign est      = W'(prod >> W2);
  assign back     = W2'(est) * W2'(s1_den);
  assign fixed    = (back > W2'(s1_num)) ? est - 1'b1 : est;
  assign den_zero = (s1_den == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      div_zero  <= 1'b0;
      quotient  <= '0;
    end else begin
      out_valid <= s1_valid;
      div_zero  <= s1_valid && den_zero;
      if (s1_valid) quotient <= den_zero ? '1 : fixed;
    end
  end
endmodule

module recip_divider_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         out_valid,
  input logic [W-1:0] quotient,
  input logic         div_zero
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && out_valid && !div_zero) |->
      ((int'(quotient) * int'($past(divisor, 2)) <= int'($past(dividend, 2))) &&
       ((int'(quotient) + 1) * int'($past(divisor, 2)) > int'($past(dividend, 2)))));

  assert_zero_quot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && div_zero) |-> (quotient == '1));

  assert_flag_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && out_valid) |-> (div_zero == ($past(divisor, 2) == '0)));

  assert_flag_only_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1 && !out_valid) |-> $stable(quotient));
endmodule

bind recip_divider recip_divider_chk #(.W(W)) chk_i (.*);

// File: tb/recip_divider_tb.sv
`timescale 1ns/1ps
module recip_divider_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         out_valid;
  logic [W-1:0] quotient;
  logic         div_zero;

  recip_divider #(.W(W)) dut_i (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    logic [W-1:0] q;
    logic         z;
    int           due;
    string        tag;
  } item_t;

  item_t        sb[$];
  int           cyc = 0;
  int           nchk = 0;
  int           nerr = 0;
  logic [W-1:0] last_q = '0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic issue(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    dividend = x;
    divisor  = y;
    it.q   = (y == 0) ? '1 : x / y;
    it.z   = (y == 0);
    it.due = cyc + 2;
    it.tag = (y == 0) ? "R5" : tag;
    sb.push_back(it);
  endtask

  task automatic idle(input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    in_valid = 1'b0;
    dividend = x;
    divisor  = y;
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R1 unexpected result", 1, 0);
        end else begin
          item_t e;
          e = sb.pop_front();
          chk(cyc == e.due, "R1 latency", cyc, e.due);
          chk(quotient == e.q, e.tag, quotient, e.q);
          chk(div_zero == e.z, e.z ? "R5 flag" : "R6 flag", div_zero, e.z);
          last_q = quotient;
        end
      end else begin
        chk(div_zero == 1'b0, "R6 flag idle", div_zero, 0);
        chk(quotient == last_q, "R8 hold", quotient, last_q);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid", out_valid, 0);
    chk(div_zero  == 1'b0, "R7 div_zero", div_zero, 0);
    chk(quotient  == '0,   "R7 quotient", quotient, 0);
    @(negedge clk);
    rst_n = 1'b1;

    issue(8'd200, 8'd1, "R4 div by one");
    issue(8'd5,   8'd9, "R4 small dividend");
    issue(8'd255, 8'd255, "R4 equal");
    issue(8'd0,   8'd7, "R4 zero dividend");
    issue(8'd77,  8'd0, "R5");
    idle(8'd9, 8'd3);
    idle(8'd100, 8'd0);
    idle(8'd250, 8'd2);
    issue(8'd0,   8'd0, "R5");
    idle(8'd1, 8'd1);
    issue(8'd254, 8'd127, "R3 directed");
    issue(8'd255, 8'd128, "R3 directed");
    idle(8'd44, 8'd5);
    idle(8'd12, 8'd4);

    // R2 and R3: every pair, back to back
    for (int x = 0; x < (1 << W); x++)
      for (int y = 0; y < (1 << W); y++)
        issue(W'(x), W'(y), "R3 sweep");

    idle('0, '0);
    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R1 all results delivered", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=0", sb.size());
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule